// File: doc/BRIEF.md
# Synchronous Buck PWM Gate Sequencer

This block turns a fixed-frequency oscillator tick and a ramp-comparator trip into the two gate commands of a synchronous buck stage. A PWM latch sets at every cycle start and clears on the comparator trip, which gives trailing-edge modulation. The high-side command follows the latch. The low-side command takes the remainder of the cycle. A dead-time counter keeps the two commands apart at every hand-over.

Two protections sit around the latch.

- **Startup block.** After reset or an idle period, the low side stays off until the high side has conducted once or soft start reports that it has passed its threshold. This stops the converter from pulling a pre-biased output down.
- **Bootstrap refresh.** After a long run at full duty, the latch is cleared at the midpoint of a cycle. The low side then turns on for the rest of that cycle and recharges the bootstrap capacitor.

An idle or fault input turns both commands off. The analog ramp, the error amplifier and the comparators lie outside the block and arrive as single-bit inputs sampled on `clk`.

Top module: `pwm_gate_seq`

## Requirements
- R1: A cycle-start tick sampled without a trip sets the PWM latch, and a trip clears it. When the start tick and a trip are sampled on the same edge, the high side stays off for that cycle (0% duty). In steady state, with the trip k clocks after the start tick and DEAD_CYC < k < P-DEAD_CYC, `gh` is high for k-DEAD_CYC clocks per P-clock cycle. `gh` rises DEAD_CYC+1 edges after the start tick.
- R2: In the same steady state, `gl` is high for P-k-DEAD_CYC clocks per cycle. With 0% duty and the low side enabled, `gl` stays high for all P clocks.
- R3: `gh` and `gl` are never high in the same clock.
- R4: Between a turn-off of one gate and the next turn-on of the other, both gates are low for at least DEAD_CYC clocks (DEAD_CYC >= 1, default 2). When the other gate is already requested, the gap is exactly DEAD_CYC clocks.
- R5: After reset and after every idle period, `gl` stays low until `gh` has been high once or `ss_high` has been sampled high.
- R6: On the edge after `idle` is sampled high, both gates are low. They stay low while `idle` is high, whatever the ticks do. `idle` also re-arms the startup block of R5 and clears the full-duty count.
- R7: After FULL_LIMIT (default 20) consecutive cycles in which the latch is never cleared, the latch is cleared on the `half_tick` edge of the next cycle. `half_tick` marks P/2 clocks after the start tick. The low side then forms one pulse of P/2-DEAD_CYC clocks that ends one edge after the following start tick. `gl` stays low during full cycles 2 to FULL_LIMIT.
- R8: Any cycle in which a trip clears the latch restarts the consecutive full-duty count from zero.
- R9: While `rst_n` is low, both gates are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | One-clock pulse at the start of each switching cycle |
| half_tick | input | 1 | One-clock pulse at the midpoint of each switching cycle |
| cmp_trip | input | 1 | Ramp comparator: COMP has crossed the ramp |
| ss_high | input | 1 | Soft-start level is above its enable threshold |
| idle | input | 1 | Fault or idle request; forces both gates off |
| gh | output | 1 | High-side gate command |
| gl | output | 1 | Low-side gate command |

## Verification
The bench builds the block with DEAD_CYC = 3 and the default FULL_LIMIT of 20. It drives a 16-clock switching cycle. It sweeps the trip position over every offset where both gates conduct, so each steady on-time and dead gap can be predicted from k, P and DEAD_CYC. The cycle is short enough that runs of 22 full-duty cycles, including one broken by a single trip, fit easily. These runs expose the midpoint refresh pulse and the restart of the count.

// File: rtl/pwm_gate_seq.sv
`timescale 1ns/1ps
module pwm_gate_seq #(
  parameter int DEAD_CYC   = 2,
  parameter int FULL_LIMIT = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic half_tick,
  input  logic cmp_trip,
  input  logic ss_high,
  input  logic idle,
  output logic gh,
  output logic gl
);
  localparam int DW = $clog2(DEAD_CYC + 1);
  localparam int FW = $clog2(FULL_LIMIT + 1);

  logic          lat;
  logic          armed;
  logic [FW-1:0] full_cnt;
  logic [DW-1:0] dt;

  wire at_limit  = (full_cnt == FW'(FULL_LIMIT));
  wire force_clr = half_tick && lat && at_limit;
  wire want_h    = lat && !idle;
  wire want_l    = !lat && armed && !idle;

  always_ff @(posedge clk) begin
    if (!rst_n || idle)              lat <= 1'b0;
    else if (cmp_trip || force_clr)  lat <= 1'b0;
    else if (cyc_start)              lat <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || idle) full_cnt <= '0;
    else if (cyc_start) begin
      if (!lat)          full_cnt <= '0;
      else if (!at_limit) full_cnt <= full_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || idle)      armed <= 1'b0;
    else if (gh || ss_high)  armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gh <= 1'b0;
      gl <= 1'b0;
      dt <= '0;
    end else if (gh && !want_h) begin
      gh <= 1'b0;
      dt <= DW'(DEAD_CYC);
    end else if (gl && !want_l) begin
      gl <= 1'b0;
      dt <= DW'(DEAD_CYC);
    end else begin
      if (dt != '0) dt <= dt - 1'b1;
      if (dt <= DW'(1)) begin
        if (want_h && !gl)      gh <= 1'b1;
        else if (want_l && !gh) gl <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_gate_seq_chk.sv
`timescale 1ns/1ps
module pwm_gate_seq_chk #(
  parameter int DEAD_CYC   = 2,
  parameter int FULL_LIMIT = 20
) (
  input logic clk,
  input logic rst_n,
  input logic cyc_start,
  input logic ss_high,
  input logic idle,
  input logic gh,
  input logic gl
);
  localparam int GW = $clog2(DEAD_CYC + 1);
  localparam int RW = $clog2(FULL_LIMIT + 2);

  logic [GW-1:0] gap;
  logic [RW-1:0] run;
  logic          seen;

  always_ff @(posedge clk) begin
    if (!rst_n)                   gap <= GW'(DEAD_CYC);
    else if (gh || gl)            gap <= '0;
    else if (gap != GW'(DEAD_CYC)) gap <= gap + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !gh) run <= '0;
    else if (cyc_start && run != RW'(FULL_LIMIT + 1)) run <= run + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || idle)     seen <= 1'b0;
    else if (gh || ss_high) seen <= 1'b1;
  end

  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n) !(gh && gl));
  a_r4_dead_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gh) || $rose(gl)) |-> (gap >= GW'(DEAD_CYC)));
  a_r5_low_side_armed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gl) |-> seen);
  a_r6_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> (!gh && !gl));
  a_r7_full_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    gh |-> (run <= RW'(FULL_LIMIT)));
endmodule

bind pwm_gate_seq pwm_gate_seq_chk #(.DEAD_CYC(DEAD_CYC), .FULL_LIMIT(FULL_LIMIT)) chk_i (
  .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .ss_high(ss_high),
  .idle(idle), .gh(gh), .gl(gl)
);

// File: tb/pwm_gate_seq_tb_top.sv
`timescale 1ns/1ps
module pwm_gate_seq_tb_top;
  localparam int P    = 16;
  localparam int DEAD = 3;
  localparam int LIM  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_start = 1'b0, half_tick = 1'b0, cmp_trip = 1'b0, ss_high = 1'b0, idle = 1'b0;
  logic gh, gl;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int lowrun = 0;
  int last_gap_h = -1, last_gap_l = -1;
  logic pgh = 1'b0, pgl = 1'b0;
  int nl_w[0:23];
  int nh_w[0:23];

  always #4 clk = ~clk;

  pwm_gate_seq #(.DEAD_CYC(DEAD), .FULL_LIMIT(LIM)) dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .half_tick(half_tick),
    .cmp_trip(cmp_trip), .ss_high(ss_high), .idle(idle), .gh(gh), .gl(gl)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (gh && gl) begin
        checks++; errors++;
        $display("FAIL R3: actual gh=%0d gl=%0d expected not both high", gh, gl);
      end
      if (gh && !pgh) last_gap_h = lowrun;
      if (gl && !pgl) last_gap_l = lowrun;
      if (gh || gl) lowrun = 0; else lowrun++;
    end
    pgh = gh;
    pgl = gl;
  end

  task automatic run_cyc(input int k, input bit trip, output int nh, output int nl);
    nh = 0; nl = 0;
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      if (gh) nh++;
      if (gl) nl++;
      cyc_start = (i == 0);
      half_tick = (i == P / 2);
      cmp_trip  = trip && (i == k);
    end
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc_start = 1'b0; half_tick = 1'b0; cmp_trip = 1'b0;
    end
  endtask

  task automatic full_run(input int n);
    int h, l;
    for (int c = 1; c <= n; c++) begin
      run_cyc(0, 1'b0, h, l);
      nh_w[c] = h;
      nl_w[c] = l;
    end
  endtask

  initial begin
    int h, l, s_l, s_h;
    repeat (4) @(negedge clk);
    chk(gh == 1'b0, "R9 gh in reset", gh, 0);
    chk(gl == 1'b0, "R9 gl in reset", gl, 0);
    rst_n = 1'b1;

    run_cyc(0, 1'b1, h, l);
    run_cyc(0, 1'b1, h, l);
    chk(h == 0, "R1 0% duty before arming gh", h, 0);
    chk(l == 0, "R5 low side blocked before first high-side pulse", l, 0);

    run_cyc(8, 1'b1, h, l);
    for (int k = DEAD + 1; k <= P - DEAD - 1; k++) begin
      run_cyc(k, 1'b1, h, l);
      run_cyc(k, 1'b1, h, l);
      chk(h == k - DEAD, $sformatf("R1 gh width k=%0d", k), h, k - DEAD);
      chk(l == P - k - DEAD, $sformatf("R2 gl width k=%0d", k), l, P - k - DEAD);
      chk(last_gap_h == DEAD, $sformatf("R4 gap before gh k=%0d", k), last_gap_h, DEAD);
      chk(last_gap_l == DEAD, $sformatf("R4 gap before gl k=%0d", k), last_gap_l, DEAD);
    end

    run_cyc(0, 1'b1, h, l);
    run_cyc(0, 1'b1, h, l);
    chk(h == 0, "R1 0% duty armed gh", h, 0);
    chk(l == P, "R2 0% duty armed gl", l, P);

    run_cyc(8, 1'b1, h, l);
    @(negedge clk);
    idle = 1'b1; cyc_start = 1'b0; cmp_trip = 1'b0; half_tick = 1'b0;
    @(negedge clk);
    chk(!gh && !gl, "R6 gates off one edge after idle", {gh, gl}, 0);
    cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0;
    s_h = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (gh || gl) s_h++;
    end
    chk(s_h == 0, "R6 gates stay off during idle with start tick", s_h, 0);
    idle = 1'b0;
    run_cyc(0, 1'b1, h, l);
    run_cyc(0, 1'b1, h, l);
    chk(l == 0, "R5 low side blocked again after idle", l, 0);
    ss_high = 1'b1;
    run_cyc(0, 1'b1, h, l);
    run_cyc(0, 1'b1, h, l);
    chk(l == P, "R5 soft-start flag enables low side", l, P);
    ss_high = 1'b0;

    run_cyc(8, 1'b1, h, l);
    run_cyc(8, 1'b1, h, l);
    full_run(22);
    s_l = 0; s_h = 0;
    for (int c = 2; c <= LIM; c++) begin s_l += nl_w[c]; s_h += nh_w[c]; end
    chk(s_l == 0, "R7 no low-side pulse in full cycles 2..20", s_l, 0);
    chk(s_h == (LIM - 1) * P, "R7 high side held through full cycles", s_h, (LIM - 1) * P);
    chk(nl_w[LIM + 1] + nl_w[LIM + 2] == P / 2 - DEAD, "R7 refresh pulse width",
        nl_w[LIM + 1] + nl_w[LIM + 2], P / 2 - DEAD);

    run_cyc(8, 1'b1, h, l);
    run_cyc(8, 1'b1, h, l);
    full_run(12);
    run_cyc(8, 1'b1, h, l);
    full_run(22);
    s_l = 0;
    for (int c = 2; c <= LIM; c++) s_l += nl_w[c];
    chk(s_l == 0, "R8 count restarted after tripped cycle", s_l, 0);
    chk(nl_w[LIM + 1] + nl_w[LIM + 2] == P / 2 - DEAD, "R8 refresh after restarted count",
        nl_w[LIM + 1] + nl_w[LIM + 2], P / 2 - DEAD);

    quiet(4);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule